// File: doc/BRIEF.md
# Strided Frame Write Address Generator

This block turns a stream of 64-bit pixel beats into a sequence of burst write requests that place an image in memory one line at a time. A configuration strobe captures the image width in pixels, the bytes per pixel, the line count, the line pitch in bytes, the frame base address and the sensor bus width. The block checks this configuration, derives the burst length and the related settings from it, and then issues requests. Each request carries an 8-byte aligned address and a beat count. After a request is accepted, the beats pass through with their own per-beat address.

Memory is 8 bytes wide. Inside a line, the address steps by 8 for each beat. At the end of a line, the address jumps to the previous line start plus the pitch, so the bytes between the end of the line and the pitch are skipped. After the last line, a one-cycle frame-done pulse is raised and the pointer returns to the frame base. A restart command moves the pointer back to the frame base at any time.

The control is a three-state machine:
- IDLE: no valid configuration is held.
- REQ: a burst request is presented.
- BURST: beats are accepted.

The transitions are:
- load-ok: any state to REQ.
- load-bad: any state to IDLE.
- restart: REQ or BURST to REQ.
- grant: REQ to BURST, when the request is accepted.
- burst-end: BURST to REQ, on the last beat of the burst.

Top module: `frame_stride_writer`

## Requirements
- R1: A configuration load is rejected in any of these cases:
  - width, height or bytes per pixel is zero;
  - width×bpp is not a multiple of 8;
  - the pitch is not a multiple of 8;
  - the pitch is smaller than width×bpp;
  - the base address is not 8-byte aligned.

  On rejection `cfg_err` is 1, the state is IDLE, and no request is made and no beat is accepted. A valid load clears `cfg_err`.
- R2: The burst length depends on the line byte count L = width×bpp. It is 16 beats when L mod 128 = 0, otherwise 8 beats when L mod 64 = 0, otherwise 4 beats. `fifo_level` reads 2, 1 or 0 for these three cases.
- R3: No burst crosses a line end. The last burst of a line carries only the beats that remain in the line (`req_beats` = min(burst length, remaining beats)).
- R4: Request and beat addresses advance by 8 for each beat within a line. The next line starts at the previous line start plus the pitch. `gap_beats` = (pitch − L)/8.
- R5: `line_bus_cycles` is width×2 when `cfg_bus8` = 1 and bpp = 2. Otherwise it is width.
- R6: `frame_done` is high for exactly one cycle, in the cycle after the last beat of the last line is accepted. The next request then uses the frame base address.
- R7: A `restart` while configured returns the pointer to the frame base and to line 0. Any open burst is dropped. `cfg_load` has priority over `restart`.
- R8: Beats are accepted only while a burst is open (`in_ready` is never high together with `req_valid`). Each burst accepts exactly `req_beats` beats.
- R9: An unaccepted request keeps its address and beat count until it is accepted or until a load or restart occurs.
- R10: After reset, `req_valid`, `in_ready`, `cfg_err` and `frame_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture and check the configuration inputs |
| cfg_width | input | WIDTH_W | Pixels per line |
| cfg_bpp | input | BPP_W | Bytes per pixel |
| cfg_height | input | HEIGHT_W | Lines per frame |
| cfg_pitch | input | PITCH_W | Line pitch in bytes |
| cfg_base | input | ADDR_W | Frame base address |
| cfg_bus8 | input | 1 | Sensor bus is 8 bits wide |
| restart | input | 1 | Return pointer to frame base |
| in_valid | input | 1 | Input beat valid |
| in_data | input | 64 | Input beat |
| in_ready | output | 1 | Input beat accepted |
| req_valid | output | 1 | Burst request valid |
| req_addr | output | ADDR_W | Burst start address |
| req_beats | output | 5 | Burst beat count |
| req_ready | input | 1 | Burst request accepted |
| wr_valid | output | 1 | Write beat valid |
| wr_addr | output | ADDR_W | Address of this beat |
| wr_data | output | 64 | Write beat data |
| wr_ready | input | 1 | Write beat accepted |
| cfg_err | output | 1 | Last load was rejected |
| fifo_level | output | 2 | Request threshold code tied to burst length |
| gap_beats | output | PITCH_W | Skipped beats between lines |
| line_bus_cycles | output | WIDTH_W+1 | Sensor bus cycles per line |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume the following about the inputs:
- `cfg_load` and `restart` are the only events allowed to withdraw a pending request or cut a burst short.
- The memory side may stall both handshakes at any time.

The stimulus keeps within these assumptions. It changes inputs only after a clock edge. It holds `req_ready` low around every load and restart, so that no request is granted in the cycle the pointer is reset. It mixes free-flowing traffic with pseudo-random stalls on `in_valid`, `req_ready` and `wr_ready`. The configurations are chosen to reach each burst length, a shortened final burst, zero and non-zero gaps, and each rejection cause.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_BURST = 2'd2
    } fsw_state_e;

    localparam int BEAT_BYTES = 8;
    localparam int DATA_W     = 64;
    localparam int BEATS_W    = 5;
endpackage

// File: rtl/fsw_cfg_decode.sv
module fsw_cfg_decode #(
    parameter int WIDTH_W  = 12,
    parameter int BPP_W    = 3,
    parameter int HEIGHT_W = 12,
    parameter int PITCH_W  = 16,
    parameter int ADDR_W   = 32,
    localparam int LB_W    = WIDTH_W + BPP_W,
    localparam int CMP_W   = (PITCH_W > LB_W) ? PITCH_W : LB_W
) (
    input  logic [WIDTH_W-1:0]  width,
    input  logic [BPP_W-1:0]    bpp,
    input  logic [HEIGHT_W-1:0] height,
    input  logic [PITCH_W-1:0]  pitch,
    input  logic [ADDR_W-1:0]   base,
    input  logic                bus8,
    output logic                bad,
    output logic [LB_W-1:0]     line_beats,
    output logic [4:0]          burst_beats,
    output logic [1:0]          fifo_code,
    output logic [PITCH_W-1:0]  gap,
    output logic [WIDTH_W:0]    bus_cycles
);
    logic [LB_W-1:0]  line_bytes;
    logic [CMP_W-1:0] pitch_x;
    logic [CMP_W-1:0] lb_x;
    logic [CMP_W-1:0] diff;

    assign line_bytes = LB_W'(width) * LB_W'(bpp);
    assign line_beats = line_bytes >> 3;
    assign pitch_x    = CMP_W'(pitch);
    assign lb_x       = CMP_W'(line_bytes);
    assign diff       = pitch_x - lb_x;
    assign gap        = PITCH_W'(diff >> 3);

    always_comb begin
        bad = (width == '0) || (height == '0) || (bpp == '0)
            || (line_bytes[2:0] != 3'd0) || (pitch[2:0] != 3'd0)
            || (pitch_x < lb_x) || (base[2:0] != 3'd0);
        if (line_bytes[6:0] == 7'd0) begin
            burst_beats = 5'd16;
            fifo_code   = 2'd2;
        end else if (line_bytes[5:0] == 6'd0) begin
            burst_beats = 5'd8;
            fifo_code   = 2'd1;
        end else begin
            burst_beats = 5'd4;
            fifo_code   = 2'd0;
        end
        if (bus8 && (bpp == BPP_W'(2)))
            bus_cycles = {width, 1'b0};
        else
            bus_cycles = {1'b0, width};
    end
endmodule

// File: rtl/fsw_burst_sizer.sv
module fsw_burst_sizer #(
    parameter int LB_W = 15
) (
    input  logic [4:0]      burst_beats,
    input  logic [LB_W-1:0] line_left,
    output logic [4:0]      req_beats
);
    always_comb begin
        if (line_left < LB_W'(burst_beats))
            req_beats = line_left[4:0];
        else
            req_beats = burst_beats;
    end
endmodule

// File: rtl/frame_stride_writer.sv
module frame_stride_writer
    import fsw_pkg::*;
#(
    parameter int WIDTH_W  = 12,
    parameter int BPP_W    = 3,
    parameter int HEIGHT_W = 12,
    parameter int PITCH_W  = 16,
    parameter int ADDR_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [WIDTH_W-1:0]  cfg_width,
    input  logic [BPP_W-1:0]    cfg_bpp,
    input  logic [HEIGHT_W-1:0] cfg_height,
    input  logic [PITCH_W-1:0]  cfg_pitch,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic                cfg_bus8,
    input  logic                restart,
    input  logic                in_valid,
    input  logic [63:0]         in_data,
    output logic                in_ready,
    output logic                req_valid,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [4:0]          req_beats,
    input  logic                req_ready,
    output logic                wr_valid,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [63:0]         wr_data,
    input  logic                wr_ready,
    output logic                cfg_err,
    output logic [1:0]          fifo_level,
    output logic [PITCH_W-1:0]  gap_beats,
    output logic [WIDTH_W:0]    line_bus_cycles,
    output logic                frame_done
);
    localparam int LB_W = WIDTH_W + BPP_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    fsw_state_e          state;
    logic                dec_bad;
    logic [LB_W-1:0]     dec_line_beats;
    logic [4:0]          dec_burst;
    logic [1:0]          dec_fifo;
    logic [PITCH_W-1:0]  dec_gap;
    logic [WIDTH_W:0]    dec_bus;

    logic [ADDR_W-1:0]   base_q;
    logic [PITCH_W-1:0]  pitch_q;
    logic [HEIGHT_W-1:0] height_q;
    logic [LB_W-1:0]     line_beats_q;
    logic [4:0]          burst_q;
    logic [ADDR_W-1:0]   cur_addr;
    logic [ADDR_W-1:0]   line_start;
    logic [LB_W-1:0]     line_left;
    logic [4:0]          burst_left;
    logic [HEIGHT_W-1:0] line_cnt;
    logic [4:0]          sized_beats;
    logic                beat_fire;

    fsw_cfg_decode #(
        .WIDTH_W(WIDTH_W), .BPP_W(BPP_W), .HEIGHT_W(HEIGHT_W),
        .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .width      (cfg_width),
        .bpp        (cfg_bpp),
        .height     (cfg_height),
        .pitch      (cfg_pitch),
        .base       (cfg_base),
        .bus8       (cfg_bus8),
        .bad        (dec_bad),
        .line_beats (dec_line_beats),
        .burst_beats(dec_burst),
        .fifo_code  (dec_fifo),
        .gap        (dec_gap),
        .bus_cycles (dec_bus)
    );

    fsw_burst_sizer #(.LB_W(LB_W)) u_sizer (
        .burst_beats(burst_q),
        .line_left  (line_left),
        .req_beats  (sized_beats)
    );

    assign beat_fire = (state == ST_BURST) && in_valid && wr_ready;

    // State register and datapath counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state           <= ST_IDLE;
            cfg_err         <= 1'b0;
            frame_done      <= 1'b0;
            base_q          <= '0;
            pitch_q         <= '0;
            height_q        <= '0;
            line_beats_q    <= '0;
            burst_q         <= 5'd4;
            fifo_level      <= 2'd0;
            gap_beats       <= '0;
            line_bus_cycles <= '0;
            cur_addr        <= '0;
            line_start      <= '0;
            line_left       <= '0;
            burst_left      <= '0;
            line_cnt        <= '0;
        end else begin
            frame_done <= 1'b0;
            if (cfg_load) begin
                if (dec_bad) begin
                    cfg_err <= 1'b1;
                    state   <= ST_IDLE;
                end else begin
                    cfg_err         <= 1'b0;
                    base_q          <= cfg_base;
                    pitch_q         <= cfg_pitch;
                    height_q        <= cfg_height;
                    line_beats_q    <= dec_line_beats;
                    burst_q         <= dec_burst;
                    fifo_level      <= dec_fifo;
                    gap_beats       <= dec_gap;
                    line_bus_cycles <= dec_bus;
                    cur_addr        <= cfg_base;
                    line_start      <= cfg_base;
                    line_left       <= dec_line_beats;
                    line_cnt        <= '0;
                    state           <= ST_REQ;
                end
            end else if (restart && (state != ST_IDLE)) begin
                cur_addr   <= base_q;
                line_start <= base_q;
                line_left  <= line_beats_q;
                line_cnt   <= '0;
                state      <= ST_REQ;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        state <= ST_IDLE;
                    end
                    ST_REQ: begin
                        if (req_ready) begin
                            burst_left <= sized_beats;
                            state      <= ST_BURST;
                        end
                    end
                    ST_BURST: begin
                        if (beat_fire) begin
                            cur_addr   <= cur_addr + STEP;
                            burst_left <= burst_left - 5'd1;
                            line_left  <= line_left - LB_W'(1);
                            if (burst_left == 5'd1) begin
                                state <= ST_REQ;
                                if (line_left == LB_W'(1)) begin
                                    line_left <= line_beats_q;
                                    if (line_cnt == height_q - HEIGHT_W'(1)) begin
                                        line_cnt   <= '0;
                                        cur_addr   <= base_q;
                                        line_start <= base_q;
                                        frame_done <= 1'b1;
                                    end else begin
                                        line_cnt   <= line_cnt + HEIGHT_W'(1);
                                        line_start <= line_start + ADDR_W'(pitch_q);
                                        cur_addr   <= line_start + ADDR_W'(pitch_q);
                                    end
                                end
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_valid = 1'b0;
        in_ready  = 1'b0;
        wr_valid  = 1'b0;
        req_addr  = cur_addr;
        req_beats = sized_beats;
        wr_addr   = cur_addr;
        wr_data   = in_data;
        unique case (state)
            ST_IDLE:  ;
            ST_REQ:   req_valid = 1'b1;
            ST_BURST: begin
                in_ready = wr_ready;
                wr_valid = in_valid;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              restart,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [4:0]        req_beats,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              cfg_err,
    input logic              frame_done
);
    logic [4:0] granted;
    logic [4:0] used;
    logic       fire;

    assign fire = wr_valid && wr_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            granted <= '0;
            used    <= '0;
        end else if (cfg_load || restart) begin
            granted <= '0;
            used    <= '0;
        end else if (req_valid && req_ready) begin
            granted <= req_beats;
            used    <= '0;
        end else if (fire) begin
            used <= used + 5'd1;
        end
    end

    // R8
    no_beat_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && in_ready));

    // R8
    beat_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cfg_load && !restart) |-> (used < granted));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !cfg_load && !restart)
        |=> (req_valid && $stable(req_addr) && $stable(req_beats)));

    // R4
    req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[2:0] == 3'd0));

    // R3
    req_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_beats != 5'd0) && (req_beats <= 5'd16)));

    // R6
    frame_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R1
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!req_valid && !in_ready));
endmodule

bind frame_stride_writer fsw_checker #(.ADDR_W(ADDR_W)) u_fsw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .restart   (restart),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_beats (req_beats),
    .in_ready  (in_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .cfg_err   (cfg_err),
    .frame_done(frame_done)
);

// File: tb/tb_frame_stride_writer.sv
module tb_frame_stride_writer;
    localparam int WIDTH_W  = 12;
    localparam int BPP_W    = 3;
    localparam int HEIGHT_W = 12;
    localparam int PITCH_W  = 16;
    localparam int ADDR_W   = 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_load = 1'b0;
    logic [WIDTH_W-1:0]  cfg_width = '0;
    logic [BPP_W-1:0]    cfg_bpp = '0;
    logic [HEIGHT_W-1:0] cfg_height = '0;
    logic [PITCH_W-1:0]  cfg_pitch = '0;
    logic [ADDR_W-1:0]   cfg_base = '0;
    logic                cfg_bus8 = 1'b0;
    logic                restart = 1'b0;
    logic                in_valid = 1'b0;
    logic [63:0]         in_data = '0;
    logic                in_ready;
    logic                req_valid;
    logic [ADDR_W-1:0]   req_addr;
    logic [4:0]          req_beats;
    logic                req_ready = 1'b0;
    logic                wr_valid;
    logic [ADDR_W-1:0]   wr_addr;
    logic [63:0]         wr_data;
    logic                wr_ready = 1'b0;
    logic                cfg_err;
    logic [1:0]          fifo_level;
    logic [PITCH_W-1:0]  gap_beats;
    logic [WIDTH_W:0]    line_bus_cycles;
    logic                frame_done;

    frame_stride_writer #(
        .WIDTH_W(WIDTH_W), .BPP_W(BPP_W), .HEIGHT_W(HEIGHT_W),
        .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)
    ) dut (.*);

    always #4 clk = ~clk;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [4:0]        beats;
    } exp_t;

    exp_t        exp_q[$];
    int          errors = 0;
    int          checks = 0;
    int          fd_cnt = 0;
    int          req_seen = 0;
    int          cycles = 0;
    logic        hold_req = 1'b1;
    logic        stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: expected requests for whole frames plus first of the next
    task automatic push_frames(input logic [ADDR_W-1:0] base, input int lb_beats,
                               input int burst, input int pitch, input int height, input int nframes);
        for (int f = 0; f < nframes; f++) begin
            for (int l = 0; l < height; l++) begin
                int left = lb_beats;
                logic [ADDR_W-1:0] a = base + ADDR_W'(l * pitch);
                while (left > 0) begin
                    int n = (left < burst) ? left : burst;
                    exp_q.push_back('{addr: a, beats: 5'(n)});
                    a = a + ADDR_W'(8 * n);
                    left = left - n;
                end
            end
        end
        exp_q.push_back('{addr: base, beats: 5'((lb_beats < burst) ? lb_beats : burst)});
    endtask

    task automatic load_cfg(input int w, input int bpp, input int h, input int p,
                            input logic [ADDR_W-1:0] base, input bit bus8);
        @(posedge clk); #1;
        cfg_width = WIDTH_W'(w); cfg_bpp = BPP_W'(bpp); cfg_height = HEIGHT_W'(h);
        cfg_pitch = PITCH_W'(p); cfg_base = base; cfg_bus8 = bus8; cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    task automatic drain();
        hold_req = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        hold_req = 1'b1;
    endtask

    task automatic run_case(input int w, input int bpp, input int h, input int p,
                            input logic [ADDR_W-1:0] base, input bit bus8, input int nframes,
                            input int burst, input int e_fifo, input int e_gap, input int e_bus,
                            input bit stall);
        int fd0;
        hold_req = 1'b1;
        stall_mode = stall;
        repeat (2) @(posedge clk);
        load_cfg(w, bpp, h, p, base, bus8);
        push_frames(base, (w * bpp) / 8, burst, p, h, nframes);
        fd0 = fd_cnt;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R1 valid load clears error", 64'(cfg_err), 64'd0);
        chk(fifo_level == 2'(e_fifo), "R2 fifo level code", 64'(fifo_level), 64'(e_fifo));
        chk(gap_beats == PITCH_W'(e_gap), "R4 gap beats", 64'(gap_beats), 64'(e_gap));
        chk(line_bus_cycles == (WIDTH_W+1)'(e_bus), "R5 bus cycles per line",
            64'(line_bus_cycles), 64'(e_bus));
        drain();
        chk(fd_cnt - fd0 == nframes, "R6 frame done count", 64'(fd_cnt - fd0), 64'(nframes));
    endtask

    // Ready / valid stimulus
    initial begin
        forever begin
            @(posedge clk); #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            req_ready = !hold_req && (!stall_mode || lfsr[0]);
            wr_ready  = !stall_mode || lfsr[1] || lfsr[2];
            in_valid  = !stall_mode || lfsr[3] || lfsr[4];
            in_data   = in_data + 64'd1;
        end
    end

    // Monitor / scoreboard
    logic [ADDR_W-1:0] bst_addr;
    int                bst_beats = 0;
    int                bst_cnt = 0;
    bit                trk = 0;
    bit                prev_fire = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit fire;
            fire = wr_valid && wr_ready;
            if (frame_done) begin
                fd_cnt++;
                chk(prev_fire, "R6 frame done follows last beat", 64'(prev_fire), 64'd1);
            end
            if (cfg_load || restart) begin
                trk = 0;
            end else begin
                if (fire && trk) begin
                    chk(wr_addr == bst_addr + ADDR_W'(8 * bst_cnt), "R4 beat address",
                        64'(wr_addr), 64'(bst_addr + ADDR_W'(8 * bst_cnt)));
                    chk(wr_data == in_data, "R8 beat data", wr_data, in_data);
                    bst_cnt++;
                end
                if (req_valid && req_ready) begin
                    req_seen++;
                    if (trk)
                        chk(bst_cnt == bst_beats, "R8 beats per burst", 64'(bst_cnt), 64'(bst_beats));
                    trk = 1;
                    bst_addr = req_addr;
                    bst_beats = int'(req_beats);
                    bst_cnt = 0;
                    if (exp_q.size() > 0) begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(req_addr == e.addr, "R4 R6 R7 request address", 64'(req_addr), 64'(e.addr));
                        chk(req_beats == e.beats, "R2 R3 request beats", 64'(req_beats), 64'(e.beats));
                    end
                end
            end
            prev_fire = fire;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seen0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(req_valid == 1'b0, "R10 req_valid after reset", 64'(req_valid), 64'd0);
        chk(in_ready == 1'b0, "R10 in_ready after reset", 64'(in_ready), 64'd0);
        chk(cfg_err == 1'b0, "R10 cfg_err after reset", 64'(cfg_err), 64'd0);
        chk(frame_done == 1'b0, "R10 frame_done after reset", 64'(frame_done), 64'd0);

        // 128-byte lines: 16-beat bursts, gap 16 beats
        run_case(64, 2, 3, 256, 32'h1000_0000, 1'b1, 2, 16, 2, 16, 128, 1'b0);
        // 96-byte lines: 4-beat bursts, no gap, 4 bytes per pixel
        run_case(24, 4, 2, 96, 32'h2000_0040, 1'b1, 2, 4, 0, 0, 24, 1'b0);
        // 80-byte lines: last burst of each line shortened to 2 (R3)
        run_case(40, 2, 2, 120, 32'h3000_0008, 1'b0, 2, 4, 0, 5, 40, 1'b0);
        // 64-byte lines: 8-beat bursts under stalls
        run_case(32, 2, 2, 64, 32'h4000_0000, 1'b1, 3, 8, 1, 0, 64, 1'b1);
        // 128-byte lines with stalls, 8-bit bus but 1 byte per pixel
        run_case(128, 1, 2, 192, 32'h5000_0100, 1'b1, 2, 16, 2, 8, 128, 1'b1);

        // R7 restart mid-frame
        hold_req = 1'b1;
        stall_mode = 1'b0;
        repeat (2) @(posedge clk);
        load_cfg(64, 2, 3, 256, 32'h6000_0000, 1'b1);
        exp_q.push_back('{addr: 32'h6000_0000, beats: 5'd16});
        exp_q.push_back('{addr: 32'h6000_0100, beats: 5'd16});
        drain();
        repeat (3) @(posedge clk);
        #1 restart = 1'b1;
        @(posedge clk); #1 restart = 1'b0;
        exp_q.push_back('{addr: 32'h6000_0000, beats: 5'd16});
        exp_q.push_back('{addr: 32'h6000_0100, beats: 5'd16});
        seen0 = fd_cnt;
        drain();
        chk(fd_cnt == seen0, "R7 no frame done after restart", 64'(fd_cnt), 64'(seen0));

        // R1 rejections: line bytes not multiple of 8, bad pitch, unaligned base, short pitch
        hold_req = 1'b1;
        repeat (2) @(posedge clk);
        load_cfg(3, 1, 2, 8, 32'h7000_0000, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R1 width*bpp not multiple of 8", 64'(cfg_err), 64'd1);
        seen0 = req_seen;
        hold_req = 1'b0;
        repeat (20) @(negedge clk);
        chk(req_seen == seen0, "R1 no request after rejection", 64'(req_seen), 64'(seen0));
        chk(in_ready == 1'b0, "R1 no beat accepted after rejection", 64'(in_ready), 64'd0);
        hold_req = 1'b1;
        load_cfg(64, 2, 2, 100, 32'h7000_0000, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R1 pitch not multiple of 8", 64'(cfg_err), 64'd1);
        load_cfg(64, 2, 2, 128, 32'h7000_0004, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R1 unaligned base", 64'(cfg_err), 64'd1);
        load_cfg(64, 2, 2, 120, 32'h7000_0000, 1'b0);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R1 pitch below line bytes", 64'(cfg_err), 64'd1);
        chk(req_valid == 1'b0, "R1 idle after rejection", 64'(req_valid), 64'd0);

        // Recovery after rejection
        run_case(16, 2, 1, 32, 32'h7000_0000, 1'b0, 3, 4, 0, 0, 16, 1'b0);

        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule